// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block sits beside a program sequencer and runs counted loops in hardware. Software issues one start command carrying the first and last body addresses, an iteration count and a mode. From then on the block watches the fetch address. When the last body instruction is fetched and more passes remain, it overrides the next fetch address with the loop's first address in that same cycle. No instruction is spent on a counter update, a compare or a backward jump.

Two modes exist. A block loop repeats an address range. A single-instruction repeat re-issues one instruction: the override keeps the fetch address where it is until the count is used up. A start command that arrives while a loop runs nests the new loop. The outer context (first address, last address, remaining count) is saved on a small last-in-first-out stack and comes back when the inner loop retires. The start command, fetch address and override are plain control pins. There is no back-pressure: the override is a same-cycle combinational answer to the fetch address, and the sequencer must use it.

Top module: `zol_loop_ctrl`

## Requirements
- R1: After reset the block is idle: `loop_active` low, `loop_depth` 0, `redirect` low and `overflow_err` low.
- R2: Block mode (`cmd_repeat`=0), count N>0: when `fetch_valid` is high and `fetch_pc` equals the last address of the innermost loop with more than one pass left, `redirect` is high in that same cycle, `redirect_pc` is the loop's first address, and the remaining count drops by one.
- R3: On the final pass (remaining count 1) the fetch at the last address gives no override, and from the next cycle the loop is retired. This means idle if no outer loop is saved, otherwise the outer context is innermost again. Without a start command an idle block stays idle.
- R4: Repeat mode (`cmd_repeat`=1) ignores `cmd_last`. The body is the single instruction at `cmd_first`, which is fetched exactly N times because its address is overridden back to itself N-1 times.
- R5: A start command with count 0 pushes nothing and changes no state. In the same cycle it raises `redirect` with `redirect_pc` equal to `cmd_last`+1 (block) or `cmd_first`+1 (repeat), modulo 2^AW. This override takes priority over a loop-back in that cycle.
- R6: A cycle with `fetch_valid` low and no start command changes nothing, even when `fetch_pc` equals a last address.
- R7: A start command with count >0 while a loop is active saves the current context and makes the new loop innermost. `loop_depth` reports the number of live loops (0 to STACK_DEPTH+1).
- R8: When the innermost loop retires at an address that is also the last address of the saved enclosing loop, that enclosing loop is evaluated in the same cycle. It loops back (with a decrement) or retires too. One enclosing level is evaluated per cycle.
- R9: A start command with count >0 while STACK_DEPTH contexts are already saved and a loop is active is dropped: the running loops go on unchanged and `overflow_err` goes high and stays high until reset.
- R10: If a start command and a last-address fetch fall in the same cycle, the fetch is evaluated first and the new loop is then stacked on top of the resulting context.
- R11: `redirect` is only raised in a cycle with `fetch_valid` or `cmd_start` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | One-cycle start command |
| cmd_first | input | AW | First body address |
| cmd_last | input | AW | Last body address (block mode only) |
| cmd_count | input | CW | Number of passes; 0 skips the body |
| cmd_repeat | input | 1 | 1 = single-instruction repeat, 0 = block loop |
| fetch_valid | input | 1 | An instruction is fetched at fetch_pc this cycle |
| fetch_pc | input | AW | Current fetch address |
| redirect | output | 1 | Override the next fetch address this cycle |
| redirect_pc | output | AW | Next fetch address when redirect is high |
| loop_active | output | 1 | At least one loop is live |
| loop_depth | output | clog2(STACK_DEPTH+2) | Number of live loops |
| overflow_err | output | 1 | Sticky: a start command found the stack full |

## Verification
Two things can land on one clock edge here. The first is the retirement of an inner loop together with the back-branch of the enclosing loop, when both share a last address. The second is a start command issued at the same fetch that ends a pass of the running loop. The bench provokes both on purpose: nested loops with a common last address, and a start command placed on a last-address fetch. It also runs a random stretch where starts, count-zero skips and stalled fetches collide freely. Each cycle is judged against a behavioural model, which applies the fetch outcome first, then an enclosing-level check, then the start command. Override, target address, depth and error flag are compared every cycle.

// File: rtl/zol_pkg.sv
package zol_pkg;
  // Levels examined per fetch: the innermost loop and one saved outer loop.
  localparam int unsigned EVAL_LEVELS = 2;

  typedef enum logic {
    MODE_BLOCK  = 1'b0,
    MODE_REPEAT = 1'b1
  } loop_mode_e;
endpackage

// File: rtl/zol_lvl_cmp.sv
// Compares the fetch address against one loop context.
module zol_lvl_cmp #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] last_addr,
  input  logic [CW-1:0] cnt,
  output logic          hit,
  output logic          final_pass
);
  assign hit        = (pc == last_addr);
  assign final_pass = (cnt == CW'(1));
endmodule

// File: rtl/zol_ctx_stack.sv
// LIFO of saved outer loop contexts. Up to two pops plus one push per cycle.
module zol_ctx_stack #(
  parameter int unsigned AW    = 16,
  parameter int unsigned CW    = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push_i,
  input  logic [1:0]                       pop_i,
  input  logic [AW-1:0]                    wr_first,
  input  logic [AW-1:0]                    wr_last,
  input  logic [CW-1:0]                    wr_cnt,
  output logic [$clog2(DEPTH+1)-1:0]       level_o,
  output logic [AW-1:0]                    top_first,
  output logic [AW-1:0]                    top_last,
  output logic [CW-1:0]                    top_cnt,
  output logic [AW-1:0]                    sub_first,
  output logic [AW-1:0]                    sub_last,
  output logic [CW-1:0]                    sub_cnt
);
  localparam int unsigned PW = $clog2(DEPTH+1);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] m_first [DEPTH];
  logic [AW-1:0] m_last  [DEPTH];
  logic [CW-1:0] m_cnt   [DEPTH];
  logic [PW-1:0] lvl_q;
  logic [PW-1:0] wr_lvl;
  logic [PW-1:0] rd0_lvl;
  logic [PW-1:0] rd1_lvl;
  logic [IW-1:0] rd0_idx;
  logic [IW-1:0] rd1_idx;

  assign wr_lvl  = lvl_q - PW'(pop_i);
  assign rd0_lvl = lvl_q - PW'(1);
  assign rd1_lvl = lvl_q - PW'(2);
  assign rd0_idx = rd0_lvl[IW-1:0];
  assign rd1_idx = rd1_lvl[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= wr_lvl + PW'(push_i);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_first[i] <= '0;
        m_last[i]  <= '0;
        m_cnt[i]   <= '0;
      end else if (push_i && (wr_lvl == PW'(i))) begin
        m_first[i] <= wr_first;
        m_last[i]  <= wr_last;
        m_cnt[i]   <= wr_cnt;
      end
    end
  end

  always_comb begin
    top_first = '0;
    top_last  = '0;
    top_cnt   = '0;
    sub_first = '0;
    sub_last  = '0;
    sub_cnt   = '0;
    if (lvl_q >= PW'(1)) begin
      top_first = m_first[rd0_idx];
      top_last  = m_last[rd0_idx];
      top_cnt   = m_cnt[rd0_idx];
    end
    if (lvl_q >= PW'(2)) begin
      sub_first = m_first[rd1_idx];
      sub_last  = m_last[rd1_idx];
      sub_cnt   = m_cnt[rd1_idx];
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/zol_loop_ctrl.sv
module zol_loop_ctrl #(
  parameter int unsigned AW          = 16,
  parameter int unsigned CW          = 16,
  parameter int unsigned STACK_DEPTH = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cmd_start,
  input  logic [AW-1:0]                      cmd_first,
  input  logic [AW-1:0]                      cmd_last,
  input  logic [CW-1:0]                      cmd_count,
  input  logic                               cmd_repeat,
  input  logic                               fetch_valid,
  input  logic [AW-1:0]                      fetch_pc,
  output logic                               redirect,
  output logic [AW-1:0]                      redirect_pc,
  output logic                               loop_active,
  output logic [$clog2(STACK_DEPTH+2)-1:0]   loop_depth,
  output logic                               overflow_err
);
  import zol_pkg::*;

  localparam int unsigned PW = $clog2(STACK_DEPTH+1);
  localparam int unsigned DW = $clog2(STACK_DEPTH+2);

  // Innermost loop context
  logic          act_q;
  logic [AW-1:0] cur_first_q;
  logic [AW-1:0] cur_last_q;
  logic [CW-1:0] cur_cnt_q;
  logic          err_q;

  // Saved contexts
  logic [PW-1:0] sp;
  logic [AW-1:0] t0_first, t0_last, t1_first, t1_last;
  logic [CW-1:0] t0_cnt, t1_cnt;

  // Level compare
  logic [AW-1:0] lv_last [EVAL_LEVELS];
  logic [CW-1:0] lv_cnt  [EVAL_LEVELS];
  logic          hit_w   [EVAL_LEVELS];
  logic          fin_w   [EVAL_LEVELS];

  assign lv_last[0] = cur_last_q;
  assign lv_cnt[0]  = cur_cnt_q;
  assign lv_last[1] = t0_last;
  assign lv_cnt[1]  = t0_cnt;

  for (genvar g = 0; g < EVAL_LEVELS; g++) begin : g_lvl
    zol_lvl_cmp #(.AW(AW), .CW(CW)) u_cmp (
      .pc         (fetch_pc),
      .last_addr  (lv_last[g]),
      .cnt        (lv_cnt[g]),
      .hit        (hit_w[g]),
      .final_pass (fin_w[g])
    );
  end

  // Stage 1: outcome of the fetch
  logic          m0, have_outer, deep2;
  logic          a_act;
  logic [AW-1:0] a_first, a_last;
  logic [CW-1:0] a_cnt;
  logic [1:0]    pop_n;
  logic          lb;
  logic [AW-1:0] lb_pc;

  assign m0         = act_q && fetch_valid && hit_w[0];
  assign have_outer = (sp != '0);
  assign deep2      = (sp >= PW'(2));

  always_comb begin
    a_act   = act_q;
    a_first = cur_first_q;
    a_last  = cur_last_q;
    a_cnt   = cur_cnt_q;
    pop_n   = 2'd0;
    lb      = 1'b0;
    lb_pc   = cur_first_q;
    if (m0) begin
      if (!fin_w[0]) begin
        a_cnt = cur_cnt_q - CW'(1);
        lb    = 1'b1;
      end else if (!have_outer) begin
        a_act = 1'b0;
      end else if (hit_w[1] && !fin_w[1]) begin
        pop_n   = 2'd1;
        a_first = t0_first;
        a_last  = t0_last;
        a_cnt   = t0_cnt - CW'(1);
        lb      = 1'b1;
        lb_pc   = t0_first;
      end else if (hit_w[1]) begin
        if (deep2) begin
          pop_n   = 2'd2;
          a_first = t1_first;
          a_last  = t1_last;
          a_cnt   = t1_cnt;
        end else begin
          pop_n = 2'd1;
          a_act = 1'b0;
        end
      end else begin
        pop_n   = 2'd1;
        a_first = t0_first;
        a_last  = t0_last;
        a_cnt   = t0_cnt;
      end
    end
  end

  // Stage 2: start command on top of the fetch outcome
  loop_mode_e    mode_w;
  logic [AW-1:0] new_last;
  logic          go, skip;
  logic [PW-1:0] sp_after;
  logic          n_act, push, set_err;
  logic [AW-1:0] n_first, n_last;
  logic [CW-1:0] n_cnt;

  assign mode_w   = loop_mode_e'(cmd_repeat);
  assign new_last = (mode_w == MODE_REPEAT) ? cmd_first : cmd_last;
  assign go       = cmd_start && (cmd_count != '0);
  assign skip     = cmd_start && (cmd_count == '0);
  assign sp_after = sp - PW'(pop_n);

  always_comb begin
    n_act   = a_act;
    n_first = a_first;
    n_last  = a_last;
    n_cnt   = a_cnt;
    push    = 1'b0;
    set_err = 1'b0;
    if (go) begin
      if (a_act && (sp_after == PW'(STACK_DEPTH))) begin
        set_err = 1'b1;
      end else begin
        push    = a_act;
        n_act   = 1'b1;
        n_first = cmd_first;
        n_last  = new_last;
        n_cnt   = cmd_count;
      end
    end
  end

  zol_ctx_stack #(.AW(AW), .CW(CW), .DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push),
    .pop_i     (pop_n),
    .wr_first  (a_first),
    .wr_last   (a_last),
    .wr_cnt    (a_cnt),
    .level_o   (sp),
    .top_first (t0_first),
    .top_last  (t0_last),
    .top_cnt   (t0_cnt),
    .sub_first (t1_first),
    .sub_last  (t1_last),
    .sub_cnt   (t1_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q       <= 1'b0;
      cur_first_q <= '0;
      cur_last_q  <= '0;
      cur_cnt_q   <= '0;
      err_q       <= 1'b0;
    end else begin
      act_q       <= n_act;
      cur_first_q <= n_first;
      cur_last_q  <= n_last;
      cur_cnt_q   <= n_cnt;
      err_q       <= err_q | set_err;
    end
  end

  assign redirect     = skip | lb;
  assign redirect_pc  = skip ? (new_last + AW'(1)) : lb_pc;
  assign loop_active  = act_q;
  assign loop_depth   = act_q ? (DW'(sp) + DW'(1)) : '0;
  assign overflow_err = err_q;
endmodule

// File: rtl/zol_loop_ctrl_chk.sv
module zol_loop_ctrl_chk #(
  parameter int unsigned AW          = 16,
  parameter int unsigned CW          = 16,
  parameter int unsigned STACK_DEPTH = 4
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              cmd_start,
  input logic [CW-1:0]                     cmd_count,
  input logic                              fetch_valid,
  input logic                              redirect,
  input logic                              loop_active,
  input logic [$clog2(STACK_DEPTH+2)-1:0]  loop_depth,
  input logic                              overflow_err
);
  assert_idle_depth_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_active |-> (loop_depth == '0));

  assert_stay_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_active && !cmd_start) |=> !loop_active);

  assert_skip_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && (cmd_count == '0)) |-> redirect);

  assert_stall_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !cmd_start) |=> $stable(loop_depth));

  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(loop_depth) <= STACK_DEPTH + 1);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);

  assert_redirect_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (fetch_valid || cmd_start));
endmodule

bind zol_loop_ctrl zol_loop_ctrl_chk #(.AW(AW), .CW(CW), .STACK_DEPTH(STACK_DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_start    (cmd_start),
  .cmd_count    (cmd_count),
  .fetch_valid  (fetch_valid),
  .redirect     (redirect),
  .loop_active  (loop_active),
  .loop_depth   (loop_depth),
  .overflow_err (overflow_err)
);

// File: tb/zol_loop_ctrl_test.sv
`timescale 1ns/1ps
module zol_loop_ctrl_test;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int SD = 4;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [AW-1:0] cmd_first = '0;
  logic [AW-1:0] cmd_last = '0;
  logic [CW-1:0] cmd_count = '0;
  logic cmd_repeat = 1'b0;
  logic fetch_valid = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic redirect;
  logic [AW-1:0] redirect_pc;
  logic loop_active;
  logic [$clog2(SD+2)-1:0] loop_depth;
  logic overflow_err;

  always #2.5 clk = ~clk;

  zol_loop_ctrl #(.AW(AW), .CW(CW), .STACK_DEPTH(SD)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_first(cmd_first),
    .cmd_last(cmd_last), .cmd_count(cmd_count), .cmd_repeat(cmd_repeat),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .redirect(redirect),
    .redirect_pc(redirect_pc), .loop_active(loop_active), .loop_depth(loop_depth),
    .overflow_err(overflow_err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int pc = 0;

  // Behavioural reference: queues of live loops, innermost at the back.
  int qf[$];
  int ql[$];
  int qc[$];
  bit merr = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // Evaluates the current cycle; commits the new state when commit is set.
  task automatic model(input bit commit, output bit rd, output int rpc);
    int f[$];
    int l[$];
    int c[$];
    bit e;
    f = qf; l = ql; c = qc; e = merr;
    rd = 0; rpc = 0;
    if (fetch_valid && f.size() > 0 && pc == l[l.size()-1]) begin
      if (c[c.size()-1] > 1) begin
        c[c.size()-1] = c[c.size()-1] - 1; rd = 1; rpc = f[f.size()-1];
      end else begin
        void'(f.pop_back()); void'(l.pop_back()); void'(c.pop_back());
        if (f.size() > 0 && pc == l[l.size()-1]) begin
          if (c[c.size()-1] > 1) begin
            c[c.size()-1] = c[c.size()-1] - 1; rd = 1; rpc = f[f.size()-1];
          end else begin
            void'(f.pop_back()); void'(l.pop_back()); void'(c.pop_back());
          end
        end
      end
    end
    if (cmd_start) begin
      if (cmd_count == 0) begin
        rd = 1;
        rpc = ((cmd_repeat ? int'(cmd_first) : int'(cmd_last)) + 1) & AMASK;
      end else if (f.size() == SD + 1) begin
        e = 1;
      end else begin
        f.push_back(int'(cmd_first));
        l.push_back(cmd_repeat ? int'(cmd_first) : int'(cmd_last));
        c.push_back(int'(cmd_count));
      end
    end
    if (commit) begin qf = f; ql = l; qc = c; merr = e; end
  endtask

  task automatic step(bit st, int f, int l, int n, bit rep, bit fv, string tag);
    bit rd;
    int rpc;
    @(negedge clk);
    cmd_start = st; cmd_first = AW'(f); cmd_last = AW'(l);
    cmd_count = CW'(n); cmd_repeat = rep; fetch_valid = fv; fetch_pc = AW'(pc);
    #1;
    check(loop_active == (qf.size() > 0), tag, "loop_active", loop_active, qf.size() > 0);
    check(int'(loop_depth) == qf.size(), tag, "loop_depth", loop_depth, qf.size());
    check(overflow_err == merr, tag, "overflow_err", overflow_err, merr);
    model(1'b1, rd, rpc);
    check(redirect == rd, tag, "redirect", redirect, rd);
    if (rd) check(int'(redirect_pc) == rpc, tag, "redirect_pc", redirect_pc, rpc);
    if (fv) pc = rd ? rpc : ((pc + 1) & AMASK);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic start_loop(int f, int l, int n, bit rep, string tag);
    step(1, f, l, n, rep, 1, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cmd_start = 0; fetch_valid = 0;
    qf.delete(); ql.delete(); qc.delete(); merr = 0; pc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog: actual=%0d expected=%0d cycles", 100000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: idle after reset
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, "R1");

    // R2/R3: block loop 10..12, three passes
    pc = 9;
    start_loop(10, 12, 3, 0, "R2");
    run(14, "R3");

    // R4: repeat the instruction at 20 four times; last address ignored
    pc = 19;
    start_loop(20, 99, 4, 1, "R4");
    run(8, "R4");

    // R5: count zero skips the body, block and repeat
    pc = 29;
    start_loop(30, 35, 0, 0, "R5");
    run(2, "R5");
    start_loop(45, 47, 0, 1, "R5");
    run(2, "R5");

    // R6: stalls on the last address change nothing
    pc = 59;
    start_loop(60, 61, 2, 0, "R6");
    run(1, "R6");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, "R6");
    run(6, "R6");

    // R7: nested loops with distinct last addresses
    pc = 69;
    start_loop(70, 80, 2, 0, "R7");
    run(2, "R7");
    start_loop(73, 75, 3, 0, "R7");
    run(40, "R7");

    // R8: inner and outer share a last address
    pc = 89;
    start_loop(90, 95, 2, 0, "R8");
    run(1, "R8");
    start_loop(92, 95, 2, 0, "R8");
    run(30, "R8");

    // R9: six nested starts; the sixth finds the stack full
    pc = 100;
    for (int k = 0; k < 6; k++) start_loop(101 + k, 130 - k, 2, 0, "R9");
    run(400, "R9");

    // R10: start command on the fetch of a last address
    do_reset();
    pc = 139;
    start_loop(140, 142, 3, 0, "R10");
    run(2, "R10");
    start_loop(150, 151, 2, 0, "R10");
    run(20, "R10");

    // R11 and collisions: random stretch
    do_reset();
    pc = 0;
    for (int i = 0; i < 600; i++) begin
      bit fv;
      bit st;
      int f;
      fv = ($urandom % 4) != 0;
      st = fv && (($urandom % 12) == 0);
      f  = pc + 1 + int'($urandom % 3);
      if (fv && !st && qf.size() == 0 && ($urandom % 8) == 0) pc = int'($urandom % 32);
      step(st, f, f + int'($urandom % 5), int'($urandom % 4), bit'($urandom % 2), fv, "R11");
      if (pc > 200) pc = 0;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule